// File: doc/BRIEF.md
# Double Frame Segment Splitter and Merger

This block carries a bus word twice as wide as a link frame across a framed link that moves one half-width segment per word cycle. Its transmit side takes a wide word with a valid strobe. It emits the two halves on consecutive cycles and tags each one with a sideband flag that says whether it is the first or the second segment. Its receive side takes segments and their flags and rebuilds the wide word. It uses the flag to realign, so it does not pair segments by count alone.

A mode input chooses between double-frame and single-frame operation. In single-frame mode the flag is an ordinary user bit that passes through on both sides, and one segment carries one word. The segment width is 16 or 20 bits, which gives wide words of 32 or 40 bits. On the receive side, a second segment with no pending first, or a first segment that replaces an unpaired one, is dropped and recorded in a sticky error bit. Line coding, serialization and clock recovery are handled elsewhere.

Top module: `dfs_link`

## Requirements
- R1: With `dbl_mode`=0, every accepted word puts its low SEG_W bits on `seg_out_data` the next cycle, with `seg_out_flag` equal to the `tx_user_flag` that came with it and `seg_out_valid`=1. `tx_ready` stays 1.
- R2: With `dbl_mode`=1, an accepted word puts its low half on the output one cycle later with flag 0. It puts its high half on the output on the following cycle with flag 1. Both cycles carry `seg_out_valid`=1.
- R3: `tx_ready` is 0 in the cycle after a double-mode acceptance. A `tx_wide_valid` in that cycle is ignored, so a new word is accepted at most every other cycle.
- R4: With `dbl_mode`=1, a valid segment with flag 0 is held. When the next valid segment has flag 1, `rx_wide_valid` pulses for one cycle on the cycle after it. `rx_wide_data` = {second segment, first segment}. Idle cycles between the two segments are allowed.
- R5: If a flag-0 segment arrives while another flag-0 segment is held, the earlier one is dropped, the new one is held, and `rx_seq_err` is set.
- R6: A flag-1 segment that arrives with no flag-0 segment held is discarded with no output, and `rx_seq_err` is set.
- R7: `rx_seq_err` stays 1 until reset.
- R8: Reset clears any pending transmit half, any held receive half and the error bit. After reset, `tx_ready`=1, `seg_out_valid`=0, `rx_wide_valid`=0 and `rx_seq_err`=0. The first segment after reset must have flag 0.
- R9: With `dbl_mode`=0, every valid received segment gives an `rx_wide_valid` pulse on the next cycle. `rx_wide_data` is the segment with its upper SEG_W bits zero, and `rx_user_flag` equals the segment's flag. Any held half is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_mode | input | 1 | 1 selects double-frame operation, 0 selects single-frame operation |
| tx_wide_data | input | 2*SEG_W | Wide word to send |
| tx_wide_valid | input | 1 | Wide word offered |
| tx_user_flag | input | 1 | User bit sent as the flag in single-frame mode |
| tx_ready | output | 1 | Word accepted when high together with valid |
| seg_out_data | output | SEG_W | Segment toward the link |
| seg_out_flag | output | 1 | Segment tag: 0 first, 1 second (user bit in single mode) |
| seg_out_valid | output | 1 | Segment present |
| seg_in_data | input | SEG_W | Segment from the link |
| seg_in_flag | input | 1 | Tag of the incoming segment |
| seg_in_valid | input | 1 | Incoming segment present |
| rx_wide_data | output | 2*SEG_W | Rebuilt word |
| rx_wide_valid | output | 1 | One-cycle pulse per rebuilt word |
| rx_user_flag | output | 1 | Received user bit in single-frame mode, 0 otherwise |
| rx_seq_err | output | 1 | Sticky segment-order error |

## Verification
A stuck or lost transmit pending bit shows up within one cycle of the next double-mode acceptance. It appears as a missing or repeated flag-1 segment, or as `tx_ready` low for the wrong cycle. A receive held bit that is stale or missing shows up at the next flag-1 segment. That segment then produces a word where none was expected, or no word where one was. A wrong error decision shows on `rx_seq_err` one cycle after the offending segment and never clears. Random segment streams with random flags reach every receive transition many times.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
   localparam int unsigned SEG_W_NARROW = 16;
   localparam int unsigned SEG_W_BROAD  = 20;

   typedef enum logic {
      SEG_FIRST  = 1'b0,
      SEG_SECOND = 1'b1
   } seg_tag_e;

   function automatic bit seg_width_ok(int unsigned w);
      return (w == SEG_W_NARROW) || (w == SEG_W_BROAD);
   endfunction
endpackage

// File: rtl/dfs_err_sticky.sv
module dfs_err_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   output logic err_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     err_o <= 1'b0;
      else if (set_i) err_o <= 1'b1;
   end

   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o); // R7
   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> err_o); // R5
endmodule

// File: rtl/dfs_tx_split.sv
module dfs_tx_split
   import dfs_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned WW   = 2 * SEG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl_mode,
   input  logic [WW-1:0]    wide_data,
   input  logic             wide_valid,
   input  logic             user_flag,
   output logic             ready,
   output logic [SEG_W-1:0] seg_data,
   output logic             seg_flag,
   output logic             seg_valid
);
   logic             pend_q;
   logic [SEG_W-1:0] hi_q;
   logic             out_dbl_q;
   logic             accept;

   assign ready  = !pend_q;
   assign accept = wide_valid && !pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         hi_q      <= '0;
         out_dbl_q <= 1'b0;
         seg_data  <= '0;
         seg_flag  <= 1'b0;
         seg_valid <= 1'b0;
      end else if (pend_q) begin
         seg_data  <= hi_q;
         seg_flag  <= SEG_SECOND;
         seg_valid <= 1'b1;
         out_dbl_q <= 1'b1;
         pend_q    <= 1'b0;
      end else if (accept) begin
         seg_data  <= wide_data[SEG_W-1:0];
         seg_valid <= 1'b1;
         if (dbl_mode) begin
            seg_flag  <= SEG_FIRST;
            hi_q      <= wide_data[WW-1:SEG_W];
            pend_q    <= 1'b1;
            out_dbl_q <= 1'b1;
         end else begin
            seg_flag  <= user_flag;
            out_dbl_q <= 1'b0;
         end
      end else begin
         seg_valid <= 1'b0;
         out_dbl_q <= 1'b0;
      end
   end

   AST_TX_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dbl_mode) |=> !ready); // R3
   AST_TX_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dbl_mode) |=> (seg_valid && !seg_flag
                                && seg_data == $past(wide_data[SEG_W-1:0]))); // R2
   AST_TX_HIGH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && out_dbl_q && !seg_flag) |=> (seg_valid && seg_flag
                                && seg_data == $past(wide_data[WW-1:SEG_W], 2))); // R2
   AST_TX_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !dbl_mode) |=> (seg_valid && seg_flag == $past(user_flag)
                                && seg_data == $past(wide_data[SEG_W-1:0]))); // R1
endmodule

// File: rtl/dfs_rx_merge.sv
module dfs_rx_merge
   import dfs_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned WW   = 2 * SEG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl_mode,
   input  logic [SEG_W-1:0] seg_data,
   input  logic             seg_flag,
   input  logic             seg_valid,
   output logic [WW-1:0]    wide_data,
   output logic             wide_valid,
   output logic             user_flag,
   output logic             seq_fault
);
   logic             held_q;
   logic [SEG_W-1:0] lo_q;
   logic             got_first;
   logic             got_second;

   assign got_first  = seg_valid && dbl_mode && (seg_flag == SEG_FIRST);
   assign got_second = seg_valid && dbl_mode && (seg_flag == SEG_SECOND);
   assign seq_fault  = (got_first && held_q) || (got_second && !held_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q     <= 1'b0;
         lo_q       <= '0;
         wide_data  <= '0;
         wide_valid <= 1'b0;
         user_flag  <= 1'b0;
      end else begin
         wide_valid <= 1'b0;
         if (!dbl_mode) begin
            held_q <= 1'b0;
            if (seg_valid) begin
               wide_data  <= {{SEG_W{1'b0}}, seg_data};
               user_flag  <= seg_flag;
               wide_valid <= 1'b1;
            end
         end else if (got_first) begin
            held_q <= 1'b1;
            lo_q   <= seg_data;
         end else if (got_second && held_q) begin
            wide_data  <= {seg_data, lo_q};
            user_flag  <= 1'b0;
            wide_valid <= 1'b1;
            held_q     <= 1'b0;
         end
      end
   end

   AST_RX_PAIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_valid && $past(dbl_mode)) |-> $past(seg_valid && seg_flag)); // R4
   AST_RX_DOUBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (got_first && held_q) |=> !wide_valid); // R5
   AST_RX_ORPHAN: assert property (@(posedge clk) disable iff (!rst_n)
      (got_second && !held_q) |=> !wide_valid); // R6
   AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !dbl_mode) |=> (wide_valid && wide_data[WW-1:SEG_W] == '0
                                    && user_flag == $past(seg_flag))); // R9
endmodule

// File: rtl/dfs_link.sv
module dfs_link
   import dfs_pkg::*;
#(
   parameter int unsigned SEG_W = 16,
   localparam int unsigned WW   = 2 * SEG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dbl_mode,
   input  logic [WW-1:0]    tx_wide_data,
   input  logic             tx_wide_valid,
   input  logic             tx_user_flag,
   output logic             tx_ready,
   output logic [SEG_W-1:0] seg_out_data,
   output logic             seg_out_flag,
   output logic             seg_out_valid,
   input  logic [SEG_W-1:0] seg_in_data,
   input  logic             seg_in_flag,
   input  logic             seg_in_valid,
   output logic [WW-1:0]    rx_wide_data,
   output logic             rx_wide_valid,
   output logic             rx_user_flag,
   output logic             rx_seq_err
);
   logic seq_fault;

   generate
      if (!seg_width_ok(SEG_W)) begin : g_bad_width
         $error("dfs_link: SEG_W must be 16 or 20");
      end
   endgenerate

   dfs_tx_split #(.SEG_W(SEG_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbl_mode   (dbl_mode),
      .wide_data  (tx_wide_data),
      .wide_valid (tx_wide_valid),
      .user_flag  (tx_user_flag),
      .ready      (tx_ready),
      .seg_data   (seg_out_data),
      .seg_flag   (seg_out_flag),
      .seg_valid  (seg_out_valid)
   );

   dfs_rx_merge #(.SEG_W(SEG_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .dbl_mode   (dbl_mode),
      .seg_data   (seg_in_data),
      .seg_flag   (seg_in_flag),
      .seg_valid  (seg_in_valid),
      .wide_data  (rx_wide_data),
      .wide_valid (rx_wide_valid),
      .user_flag  (rx_user_flag),
      .seq_fault  (seq_fault)
   );

   dfs_err_sticky u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (seq_fault),
      .err_o (rx_seq_err)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (tx_ready && !seg_out_valid && !rx_wide_valid && !rx_seq_err)); // R8
endmodule

// File: tb/dfs_link_bench.sv
module dfs_link_bench;
   localparam int unsigned SEG_W = 16;
   localparam int unsigned WW    = 2 * SEG_W;
   localparam time CLK_P = 20ns;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             dbl_mode = 1'b1;
   logic [WW-1:0]    tx_wide_data = '0;
   logic             tx_wide_valid = 1'b0;
   logic             tx_user_flag = 1'b0;
   logic             tx_ready;
   logic [SEG_W-1:0] seg_out_data;
   logic             seg_out_flag;
   logic             seg_out_valid;
   logic [SEG_W-1:0] seg_in_data = '0;
   logic             seg_in_flag = 1'b0;
   logic             seg_in_valid = 1'b0;
   logic [WW-1:0]    rx_wide_data;
   logic             rx_wide_valid;
   logic             rx_user_flag;
   logic             rx_seq_err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // model state
   bit             m_pend;
   logic [SEG_W-1:0] m_hi;
   bit             m_held;
   logic [SEG_W-1:0] m_lo;
   bit             m_err;

   always #(CLK_P/2) clk = ~clk;

   dfs_link #(.SEG_W(SEG_W)) u_dfs_link (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
      .tx_wide_data(tx_wide_data), .tx_wide_valid(tx_wide_valid),
      .tx_user_flag(tx_user_flag), .tx_ready(tx_ready),
      .seg_out_data(seg_out_data), .seg_out_flag(seg_out_flag),
      .seg_out_valid(seg_out_valid),
      .seg_in_data(seg_in_data), .seg_in_flag(seg_in_flag),
      .seg_in_valid(seg_in_valid),
      .rx_wide_data(rx_wide_data), .rx_wide_valid(rx_wide_valid),
      .rx_user_flag(rx_user_flag), .rx_seq_err(rx_seq_err)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [WW-1:0] join_halves(logic [SEG_W-1:0] hi, logic [SEG_W-1:0] lo);
      return {hi, lo};
   endfunction

   // One clock: inputs already driven; predict, clock, compare.
   task automatic step();
      bit e_sv, e_sf, e_rv, e_rf, acc, fault_first, fault_orphan;
      logic [SEG_W-1:0] e_sd;
      logic [WW-1:0]    e_rd;
      string tx_tag, rx_tag;
      e_sv = 0; e_sf = 0; e_sd = '0; e_rv = 0; e_rf = 0; e_rd = '0;
      fault_first = 0; fault_orphan = 0;
      tx_tag = dbl_mode ? "R2" : "R1";
      chk(tx_ready == !m_pend, "R3", 64'(tx_ready), 64'(!m_pend));
      acc = tx_wide_valid && !m_pend;
      if (m_pend) begin
         e_sv = 1; e_sf = 1; e_sd = m_hi; m_pend = 0; tx_tag = "R2";
      end else if (acc) begin
         e_sv = 1; e_sd = tx_wide_data[SEG_W-1:0];
         if (dbl_mode) begin
            e_sf = 0; m_pend = 1; m_hi = tx_wide_data[WW-1:SEG_W];
         end else e_sf = tx_user_flag;
      end
      rx_tag = dbl_mode ? "R4" : "R9";
      if (!dbl_mode) begin
         m_held = 0;
         if (seg_in_valid) begin
            e_rv = 1; e_rd = {{SEG_W{1'b0}}, seg_in_data}; e_rf = seg_in_flag;
         end
      end else if (seg_in_valid && !seg_in_flag) begin
         if (m_held) begin m_err = 1; fault_first = 1; end
         m_held = 1; m_lo = seg_in_data;
      end else if (seg_in_valid && seg_in_flag) begin
         if (m_held) begin
            e_rv = 1; e_rd = join_halves(seg_in_data, m_lo); m_held = 0;
         end else begin m_err = 1; fault_orphan = 1; end
      end
      @(posedge clk);
      @(negedge clk);
      chk(seg_out_valid == e_sv, tx_tag, 64'(seg_out_valid), 64'(e_sv));
      if (e_sv) begin
         chk(seg_out_data == e_sd, tx_tag, 64'(seg_out_data), 64'(e_sd));
         chk(seg_out_flag == e_sf, tx_tag, 64'(seg_out_flag), 64'(e_sf));
      end
      if (fault_first) rx_tag = "R5";
      if (fault_orphan) rx_tag = "R6";
      chk(rx_wide_valid == e_rv, rx_tag, 64'(rx_wide_valid), 64'(e_rv));
      if (e_rv) begin
         chk(rx_wide_data == e_rd, rx_tag, 64'(rx_wide_data), 64'(e_rd));
         if (!dbl_mode) chk(rx_user_flag == e_rf, "R9", 64'(rx_user_flag), 64'(e_rf));
      end
      chk(rx_seq_err == m_err, (fault_first || fault_orphan) ? rx_tag : "R7",
          64'(rx_seq_err), 64'(m_err));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tx_wide_valid = 0; seg_in_valid = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_pend = 0; m_held = 0; m_err = 0;
      chk(tx_ready == 1'b1, "R8", 64'(tx_ready), 64'd1);
      chk(seg_out_valid == 1'b0, "R8", 64'(seg_out_valid), 64'd0);
      chk(rx_wide_valid == 1'b0, "R8", 64'(rx_wide_valid), 64'd0);
      chk(rx_seq_err == 1'b0, "R8", 64'(rx_seq_err), 64'd0);
   endtask

   task automatic rx_seg(input bit v, input bit f, input logic [SEG_W-1:0] d);
      seg_in_valid = v; seg_in_flag = f; seg_in_data = d;
      step();
   endtask

   task automatic rand_cycles(input int n, input int err_pct);
      for (int i = 0; i < n; i++) begin
         logic [63:0] r;
         r = {$urandom(), $urandom()};
         tx_wide_data  = r[WW-1:0];
         tx_wide_valid = ($urandom() % 10) < 7;
         tx_user_flag  = $urandom() % 2;
         seg_in_valid  = ($urandom() % 10) < 6;
         seg_in_data   = SEG_W'($urandom());
         if (($urandom() % 100) < err_pct) seg_in_flag = $urandom() % 2;
         else seg_in_flag = m_held;  // well-ordered stream
         step();
      end
   endtask

   initial begin
      void'($urandom(32'd4321));
      do_reset();
      // R2 R3: directed back-to-back offers in double mode
      dbl_mode = 1;
      tx_wide_data = 32'hBEEF_1234; tx_wide_valid = 1; step();
      tx_wide_data = 32'hDEAD_5678; step();            // R3: ignored, ready low
      tx_wide_data = 32'hCAFE_9ABC; step();            // accepted
      tx_wide_valid = 0; step(); step();
      // R4: ordered pair with idle gap
      rx_seg(1, 0, 16'h1111); rx_seg(0, 0, 16'h0); rx_seg(1, 1, 16'h2222);
      rx_seg(0, 0, 16'h0);
      // R5: two firsts in a row, then a second pairs with the later one
      rx_seg(1, 0, 16'hAAAA); rx_seg(1, 0, 16'hBBBB); rx_seg(1, 1, 16'hCCCC);
      chk(rx_seq_err == 1'b1, "R5", 64'(rx_seq_err), 64'd1);
      do_reset();
      // R6: orphan second
      rx_seg(1, 1, 16'h3333); rx_seg(0, 0, 16'h0);
      chk(rx_wide_valid == 1'b0, "R6", 64'(rx_wide_valid), 64'd0);
      // R7: error persists across good traffic
      rx_seg(1, 0, 16'h4444); rx_seg(1, 1, 16'h5555);
      chk(rx_seq_err == 1'b1, "R7", 64'(rx_seq_err), 64'd1);
      // R8: reset in mid-pair drops the held half
      do_reset();
      rx_seg(1, 0, 16'h6666);
      tx_wide_data = 32'h7777_8888; tx_wide_valid = 1; step(); tx_wide_valid = 0;
      do_reset();
      rx_seg(1, 1, 16'h9999);
      chk(rx_seq_err == 1'b1, "R8", 64'(rx_seq_err), 64'd1);
      do_reset();
      // R9 / R1: single mode
      dbl_mode = 0;
      rx_seg(1, 1, 16'hABCD); rx_seg(1, 0, 16'h1357);
      tx_wide_data = 32'h2468_ACE0; tx_user_flag = 1; tx_wide_valid = 1; step(); step();
      tx_wide_valid = 0;
      rand_cycles(400, 20);
      // random double mode, mostly ordered, then with many faults
      do_reset();
      dbl_mode = 1;
      rand_cycles(2000, 0);
      chk(rx_seq_err == 1'b0, "R4", 64'(rx_seq_err), 64'd0);
      rand_cycles(2000, 40);
      // mode toggling mid-stream
      for (int k = 0; k < 20; k++) begin
         dbl_mode = $urandom() % 2;
         rand_cycles(50, 30);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule